// File: doc/BRIEF.md
# Seconds-Counting Clock Register Block with Interrupts

This block keeps time as a 32-bit count of seconds and exposes it, together with an alarm, a control word and two interrupt groups, through a word-wide register bus. A prescaler divides the system clock by `PRESCALE` to make a one-cycle strobe at every second boundary. The sub-second phase of that prescaler can be read back. Software can schedule a new seconds value, and the block loads it at the next boundary.

Each interrupt group has three parts: a status register whose bits software clears by writing one, a mask that software cannot write directly, and a pair of strobe registers. One strobe register writes ones to clear mask bits and the other writes ones to set them. The clock group has two sources: the second boundary and the alarm match. The second group has a single source, which is any bus access that does not land on a mapped, word-aligned register. Each group drives one level interrupt output. An asynchronous active-low reset is brought into the clock domain before it reaches the registers.

Top module: `rtc_regblk`

## Requirements
- R1: The seconds count increases by exactly one every `PRESCALE` clock cycles. The sub-second register at offset 0x08 reads the number of cycles elapsed since the last boundary, from 0 to `PRESCALE`-1.
- R2: A write to the load register at offset 0x04 takes effect at the first second boundary after the write. The count then takes the written value and counts on from it.
- R3: Clock-group status bit 0 is set at every second boundary. Status bit 1 is set at a boundary whose new count equals the alarm register at offset 0x0C. The alarm register can be read and written.
- R4: The status registers at 0x10 (clock group, bits 1:0) and 0x20 (error group, bit 0) clear a bit when a one is written to it. Writing zero to a bit leaves it unchanged. If a hardware set and a clearing write hit the same bit in the same cycle, the set wins.
- R5: The masks at 0x14 (reset value 0x3) and 0x24 (reset value 0x1) ignore bus writes. Writing ones to the enable registers (0x18 and 0x28) clears the corresponding mask bits. Writing ones to the disable registers (0x1C and 0x2C) sets them. The enable and disable registers always read as 0.
- R6: `irq_rtc` and `irq_aerr` each equal the OR of the group's status AND NOT mask. They are low after reset and settle in the cycle after any write that changes status or mask.
- R7: A read or write with a nonzero address[1:0], or with a word index past the control register (offset 0x34 and above), sets error status bit 0. Such a read returns 0, and such a write changes no register.
- R8: The control register at 0x30 resets to 0x01000000. Only the bits in 0x8F000001 can be written, and all other bits read as 0.
- R9: Reads are registered: `bus_rdata` shows the addressed register one cycle after `bus_rd`. The current seconds count can be read at offsets 0x00 and 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address inside the register window |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_wdata | input | 32 | Write data, little-endian word |
| bus_rdata | output | 32 | Registered read data |
| irq_rtc | output | 1 | Clock-group level interrupt |
| irq_aerr | output | 1 | Address-error level interrupt |

## Verification
A write changes the register state at the clock edge where it is presented, so the interrupt levels are sampled half a cycle later. Read data arrives one edge after the strobe and holds the register value from before that edge. For this reason, a count that changes at a boundary edge is visible only to a read presented on a later edge. The bench first locks onto a boundary by streaming sub-second reads until it sees `PRESCALE`-1. It then counts edges to place loads, clearing writes and reads exactly, including a clearing write that lands on the boundary edge itself.

// File: rtl/rtc_regblk_pkg.sv
package rtc_regblk_pkg;

  typedef logic [31:0] word_t;

  // word indices (byte offset = index * 4)
  localparam int IX_SEC_NOW   = 0;
  localparam int IX_SEC_LOAD  = 1;
  localparam int IX_SUBSEC    = 2;
  localparam int IX_ALARM     = 3;
  localparam int IX_IRQ_STAT  = 4;
  localparam int IX_IRQ_MASK  = 5;
  localparam int IX_IRQ_EN    = 6;
  localparam int IX_IRQ_DIS   = 7;
  localparam int IX_AERR_STAT = 8;
  localparam int IX_AERR_MASK = 9;
  localparam int IX_AERR_EN   = 10;
  localparam int IX_AERR_DIS  = 11;
  localparam int IX_CTRL      = 12;
  localparam int NUM_REGS     = 13;

  localparam int RTC_SRCS  = 2;
  localparam int AERR_SRCS = 1;

  localparam word_t CTRL_RST   = 32'h0100_0000;
  localparam word_t CTRL_WMASK = 32'h8F00_0001;

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int PRESCALE = 32768,
  parameter int SUB_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SUB_W-1:0] phase_o,
  output logic             sec_stb_o
);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(PRESCALE - 1);

  logic [SUB_W-1:0] cnt_q, cnt_nxt;

  assign sec_stb_o = (cnt_q == LAST);
  assign phase_o   = cnt_q;

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    if (sec_stb_o) cnt_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_stb_i,
  input  logic             load_wr_i,
  input  logic [SEC_W-1:0] load_val_i,
  input  logic [SEC_W-1:0] alarm_i,
  output logic [SEC_W-1:0] sec_o,
  output logic             pend_o,
  output logic             alarm_hit_o
);
  logic [SEC_W-1:0] sec_q, sec_nxt, ld_q, ld_nxt;
  logic             pend_q, pend_nxt;

  always_comb begin
    sec_nxt  = sec_q;
    ld_nxt   = ld_q;
    pend_nxt = pend_q;
    if (sec_stb_i) begin
      sec_nxt  = pend_q ? ld_q : sec_q + 1'b1;
      pend_nxt = 1'b0;
    end
    // a load written on a boundary edge waits for the following boundary
    if (load_wr_i) begin
      ld_nxt   = load_val_i;
      pend_nxt = 1'b1;
    end
  end

  assign alarm_hit_o = sec_stb_i && (sec_nxt == alarm_i);
  assign sec_o       = sec_q;
  assign pend_o      = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ld_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      sec_q  <= sec_nxt;
      ld_q   <= ld_nxt;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/rtc_irq_grp.sv
module rtc_irq_grp #(
  parameter int         N        = 2,
  parameter logic [N-1:0] MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] wdata_i,
  input  logic         stat_wr_i,
  input  logic         en_wr_i,
  input  logic         dis_wr_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q, stat_nxt, mask_q, mask_nxt;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_comb begin
      stat_nxt[b] = stat_q[b];
      if (stat_wr_i && wdata_i[b]) stat_nxt[b] = 1'b0;
      if (set_i[b])                stat_nxt[b] = 1'b1;
      mask_nxt[b] = mask_q[b];
      if (en_wr_i && wdata_i[b])   mask_nxt[b] = 1'b0;
      if (dis_wr_i && wdata_i[b])  mask_nxt[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      stat_q <= stat_nxt;
      mask_q <= mask_nxt;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);
endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
  import rtc_regblk_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_rtc,
  output logic              irq_aerr
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SUB_W = 16;

  // reset: asynchronous assert, synchronous release
  logic rst_s0, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_s0} <= 2'b00;
    else        {rst_sync_n, rst_s0} <= {rst_s0, 1'b1};
  end

  // decode
  logic [IDX_W-1:0]    widx;
  logic                hit;
  logic [NUM_REGS-1:0] sel;
  logic                aerr_evt;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign hit      = (bus_addr[1:0] == 2'b00) && (widx < IDX_W'(NUM_REGS));
  assign aerr_evt = (bus_rd || bus_wr) && !hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = hit && (widx == IDX_W'(g));
  end

  // time base
  logic [SUB_W-1:0] phase;
  logic             sec_stb;
  logic [31:0]      sec_count;
  logic             load_pend;
  logic             alarm_hit;
  word_t            alarm_q, alarm_nxt, ctrl_q, ctrl_nxt;

  rtc_tick_gen #(.PRESCALE(PRESCALE), .SUB_W(SUB_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase_o   (phase),
    .sec_stb_o (sec_stb)
  );

  rtc_sec_count #(.SEC_W(32)) u_sec (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sec_stb_i   (sec_stb),
    .load_wr_i   (bus_wr && sel[IX_SEC_LOAD]),
    .load_val_i  (bus_wdata),
    .alarm_i     (alarm_q),
    .sec_o       (sec_count),
    .pend_o      (load_pend),
    .alarm_hit_o (alarm_hit)
  );

  // interrupt groups
  logic [RTC_SRCS-1:0]  irq_stat, irq_mask;
  logic [AERR_SRCS-1:0] aerr_stat, aerr_mask;

  rtc_irq_grp #(.N(RTC_SRCS), .MASK_RST('1)) u_irq_rtc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     ({alarm_hit, sec_stb}),
    .wdata_i   (bus_wdata[RTC_SRCS-1:0]),
    .stat_wr_i (bus_wr && sel[IX_IRQ_STAT]),
    .en_wr_i   (bus_wr && sel[IX_IRQ_EN]),
    .dis_wr_i  (bus_wr && sel[IX_IRQ_DIS]),
    .stat_o    (irq_stat),
    .mask_o    (irq_mask),
    .irq_o     (irq_rtc)
  );

  rtc_irq_grp #(.N(AERR_SRCS), .MASK_RST('1)) u_irq_aerr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     (aerr_evt),
    .wdata_i   (bus_wdata[AERR_SRCS-1:0]),
    .stat_wr_i (bus_wr && sel[IX_AERR_STAT]),
    .en_wr_i   (bus_wr && sel[IX_AERR_EN]),
    .dis_wr_i  (bus_wr && sel[IX_AERR_DIS]),
    .stat_o    (aerr_stat),
    .mask_o    (aerr_mask),
    .irq_o     (irq_aerr)
  );

  // plain storage registers
  always_comb begin
    alarm_nxt = alarm_q;
    ctrl_nxt  = ctrl_q;
    if (bus_wr && sel[IX_ALARM]) alarm_nxt = bus_wdata;
    if (bus_wr && sel[IX_CTRL])  ctrl_nxt  = bus_wdata & CTRL_WMASK;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      alarm_q <= '0;
      ctrl_q  <= CTRL_RST;
    end else begin
      alarm_q <= alarm_nxt;
      ctrl_q  <= ctrl_nxt;
    end
  end

  // read path
  word_t rd_nxt, rdata_q;
  always_comb begin
    rd_nxt = '0;
    if (sel[IX_SEC_NOW] || sel[IX_SEC_LOAD]) rd_nxt = sec_count;
    if (sel[IX_SUBSEC])    rd_nxt = 32'(phase);
    if (sel[IX_ALARM])     rd_nxt = alarm_q;
    if (sel[IX_IRQ_STAT])  rd_nxt = 32'(irq_stat);
    if (sel[IX_IRQ_MASK])  rd_nxt = 32'(irq_mask);
    if (sel[IX_AERR_STAT]) rd_nxt = 32'(aerr_stat);
    if (sel[IX_AERR_MASK]) rd_nxt = 32'(aerr_mask);
    if (sel[IX_CTRL])      rd_nxt = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_rd)  rdata_q <= rd_nxt;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/rtc_regblk_chk.sv
module rtc_regblk_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [1:0]        irq_stat,
  input logic [1:0]        irq_mask,
  input logic [0:0]        aerr_stat,
  input logic [31:0]       sec_count,
  input logic              sec_stb,
  input logic              load_pend
);
  logic [ADDR_W-3:0] cidx;
  logic              unmapped;
  assign cidx     = bus_addr[ADDR_W-1:2];
  assign unmapped = (bus_addr[1:0] != 2'b00) || (cidx > (ADDR_W-2)'(12));

  // R1
  sec_advance_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sec_stb && !load_pend |=> sec_count == $past(sec_count) + 32'd1);

  // R1
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sec_stb |=> $stable(sec_count));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_wr && !unmapped && cidx == (ADDR_W-2)'(4) && !sec_stb
    |=> (irq_stat & $past(bus_wdata[1:0])) == 2'b00);

  // R5
  en_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_wr && !unmapped && cidx == (ADDR_W-2)'(6)
    |=> (irq_mask & $past(bus_wdata[1:0])) == 2'b00);

  // R5
  dis_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_wr && !unmapped && cidx == (ADDR_W-2)'(7)
    |=> (irq_mask & $past(bus_wdata[1:0])) == $past(bus_wdata[1:0]));

  // R7
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rd && unmapped |=> bus_rdata == 32'd0);

  // R7
  bad_access_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd || bus_wr) && unmapped |=> aerr_stat[0]);

  // R8
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rd && !unmapped && cidx == (ADDR_W-2)'(12)
    |=> (bus_rdata & ~32'h8F00_0001) == 32'd0);
endmodule

bind rtc_regblk rtc_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_stat   (irq_stat),
  .irq_mask   (irq_mask),
  .aerr_stat  (aerr_stat),
  .sec_count  (sec_count),
  .sec_stb    (sec_stb),
  .load_pend  (load_pend)
);

// File: tb/rtc_regblk_tb.sv
module rtc_regblk_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PRESC      = 4;
  localparam int  AW         = 6;
  localparam int  NV         = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_rtc, irq_aerr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regblk #(.PRESCALE(PRESC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rtc(irq_rtc), .irq_aerr(irq_aerr)
  );

  // {req[3:0], wr, addr[7:0], data[31:0], irq{aerr,rtc}[1:0]}
  // read rows: data is the expected read value
  localparam logic [46:0] VEC [NV] = '{
    {4'd5, 1'b0, 8'h14, 32'h0000_0003, 2'b00}, // R5 mask reset
    {4'd5, 1'b0, 8'h24, 32'h0000_0001, 2'b00}, // R5
    {4'd5, 1'b1, 8'h14, 32'h0000_0000, 2'b00}, // R5 write to ro mask
    {4'd5, 1'b0, 8'h14, 32'h0000_0003, 2'b00}, // R5
    {4'd5, 1'b0, 8'h18, 32'h0000_0000, 2'b00}, // R5 enable reads 0
    {4'd5, 1'b0, 8'h2C, 32'h0000_0000, 2'b00}, // R5 disable reads 0
    {4'd8, 1'b0, 8'h30, 32'h0100_0000, 2'b00}, // R8
    {4'd8, 1'b1, 8'h30, 32'hFFFF_FFFF, 2'b00}, // R8
    {4'd8, 1'b0, 8'h30, 32'h8F00_0001, 2'b00}, // R8
    {4'd8, 1'b1, 8'h30, 32'h0000_0000, 2'b00}, // R8
    {4'd8, 1'b0, 8'h30, 32'h0000_0000, 2'b00}, // R8
    {4'd3, 1'b1, 8'h0C, 32'h1234_5678, 2'b00}, // R3 alarm rw
    {4'd3, 1'b0, 8'h0C, 32'h1234_5678, 2'b00}, // R3
    {4'd7, 1'b0, 8'h20, 32'h0000_0000, 2'b00}, // R7
    {4'd7, 1'b0, 8'h34, 32'h0000_0000, 2'b00}, // R7 unmapped read
    {4'd7, 1'b0, 8'h20, 32'h0000_0001, 2'b00}, // R7
    {4'd6, 1'b1, 8'h28, 32'h0000_0001, 2'b10}, // R6 unmask error
    {4'd5, 1'b0, 8'h24, 32'h0000_0000, 2'b10}, // R5
    {4'd4, 1'b1, 8'h20, 32'h0000_0000, 2'b10}, // R4 write 0
    {4'd4, 1'b0, 8'h20, 32'h0000_0001, 2'b10}, // R4
    {4'd4, 1'b1, 8'h20, 32'h0000_0001, 2'b00}, // R4 w1c
    {4'd4, 1'b0, 8'h20, 32'h0000_0000, 2'b00}, // R4
    {4'd7, 1'b1, 8'h3C, 32'h0000_DEAD, 2'b10}, // R7 unmapped write
    {4'd5, 1'b1, 8'h2C, 32'h0000_0001, 2'b00}, // R5 disable
    {4'd5, 1'b0, 8'h24, 32'h0000_0001, 2'b00}, // R5
    {4'd4, 1'b1, 8'h20, 32'h0000_0001, 2'b00}, // R4
    {4'd7, 1'b0, 8'h02, 32'h0000_0000, 2'b00}, // R7 misaligned read
    {4'd7, 1'b0, 8'h20, 32'h0000_0001, 2'b00}, // R7
    {4'd7, 1'b1, 8'h0E, 32'hFFFF_FFFF, 2'b00}, // R7 misaligned write
    {4'd7, 1'b0, 8'h0C, 32'h1234_5678, 2'b00}  // R7 alarm untouched
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a[AW-1:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[AW-1:0]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // leaves the bench at the negedge right after a boundary edge E
  task automatic sync_second();
    bus_addr = 8'h08; bus_rd = 1'b1;
    for (int i = 0; i < 4 * PRESC; i++) begin
      @(negedge clk);
      if (bus_rdata == 32'(PRESC - 1)) break;
    end
    bus_rd = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d, s0;
    idle(3);
    // R6 reset state of outputs
    check(irq_rtc == 1'b0 && irq_aerr == 1'b0, "R6 reset irq", {30'd0, irq_aerr, irq_rtc}, 0);
    check(bus_rdata == 32'd0, "R9 reset rdata", bus_rdata, 0);
    rst_n = 1'b1;
    idle(4);

    for (int v = 0; v < NV; v++) begin
      logic [46:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[46:43], v);
      if (e[42]) wr(e[41:34], e[33:2]);
      else begin
        rd(e[41:34], d);
        check(d == e[33:2], tag, d, e[33:2]);
      end
      check({irq_aerr, irq_rtc} == e[1:0], {tag, " irq"},
            {30'd0, irq_aerr, irq_rtc}, {30'd0, e[1:0]});
    end

    // R1 sub-second phase and seconds rate
    sync_second();
    rd(8'h08, d); check(d == 32'd0, "R1 phase0", d, 0);
    rd(8'h08, d); check(d == 32'd1, "R1 phase1", d, 1);
    rd(8'h00, s0);
    idle(7);
    rd(8'h00, d); check(d == s0 + 32'd2, "R1 two seconds", d, s0 + 32'd2);

    // R2 / R3 load at boundary, alarm match
    sync_second();
    wr(8'h0C, 32'h100);           // E+1 alarm
    wr(8'h04, 32'h100);           // E+2 load
    idle(2);                      // E+3, E+4 boundary
    rd(8'h00, d); check(d == 32'h100, "R2 load applied", d, 32'h100);
    rd(8'h10, d); check(d[1:0] == 2'b11, "R3 tick and alarm status", d, 3);
    wr(8'h18, 32'h2);             // E+7 unmask alarm
    check(irq_rtc == 1'b1, "R6 alarm irq", {31'd0, irq_rtc}, 1);
    wr(8'h10, 32'h2);             // E+8 clear alarm
    check(irq_rtc == 1'b0, "R4 alarm cleared", {31'd0, irq_rtc}, 0);
    rd(8'h00, d); check(d == 32'h101, "R2 counts on", d, 32'h101);
    rd(8'h04, d); check(d == 32'h101, "R9 load offset reads count", d, 32'h101);

    // R4 set beats clear on the boundary edge
    sync_second();
    idle(3);
    wr(8'h10, 32'h1);             // E+4 = boundary
    rd(8'h10, d); check(d[0] == 1'b1, "R4 set wins", d, 1);
    wr(8'h10, 32'h1);             // E+6
    rd(8'h10, d); check(d[0] == 1'b0, "R4 cleared off boundary", d, 0);

    // R6 seconds interrupt
    wr(8'h18, 32'h1);
    idle(PRESC + 1);
    check(irq_rtc == 1'b1, "R6 tick irq", {31'd0, irq_rtc}, 1);
    wr(8'h1C, 32'h3);
    check(irq_rtc == 1'b0, "R6 masked again", {31'd0, irq_rtc}, 0);
    rd(8'h14, d); check(d == 32'h3, "R5 disable sets", d, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule